// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous host and an asynchronous fast page mode DRAM array 72 bits wide, eight of those bits being check bits that the host supplies and reads back untouched. A host request (valid/ready, with address, write flag and write data) becomes a sequence on the memory pins. First the row address is put on a shared address bus with the row strobe, then the column address with the column strobe. A read returns one 72-bit word on a result strobe.

Once a row is open it stays open. Further requests to the same row are served as page-mode column cycles in which only the column strobe toggles. A request to another row, a refresh request or the page-length guard closes the row and precharges it first. Every analog timing limit is turned into a clock-cycle count by rounding the nanosecond minimum up against the clock period parameter. A grade parameter picks the fast or slow timing set. The data bus is split into out, enable and in, so the pad ring can build the tristate driver.

Top module: `fpm_ctrl`

## Requirements
- R1: In reset and afterwards, both strobes, write enable and output enable are high (inactive) and the data driver is off. `req_ready` stays low for exactly T_RP cycles after reset is released and rises in the following cycle.
- R2: The host address splits as row = `req_addr[2*AW-1:AW]`, column = `req_addr[AW-1:0]`. The row is on `dram_addr` when the row strobe falls, the column when the column strobe falls, and the column strobe is only low while the row strobe is low.
- R3: The row strobe is high for at least T_RP = ceil(precharge ns / clock ns) cycles (30 ns fast, 40 ns slow) before every falling edge.
- R4: The column strobe falls no earlier than T_RCD = ceil(18 ns / clock) cycles after the row strobe falls.
- R5: Same-row requests that arrive while the row is open are served without raising the row strobe. Successive column falls are at least ceil(35 or 40 ns / clock) cycles apart, with the column strobe high for at least ceil(10 ns / clock) cycles between them.
- R6: A request to a different row raises the row strobe, precharges, and opens the new row with a fresh row-strobe fall.
- R7: For a read, output enable is low only while the column strobe is low and write enable is high. The data is sampled at the end of the column window, which is long enough for both the column access time (18/20 ns) and the row access time (50/60 ns). It returns on `rd_data` with a one-cycle `rd_valid` pulse, in request order.
- R8: A write is an early write. Write enable falls on the same edge as the column strobe, output enable stays high, and the write data is driven for the whole column-low window.
- R9: The row strobe is never low for more than floor(RAS_MAX_NS / clock) cycles. The page closes before that limit even while same-row requests keep arriving.
- R10: A high `refresh_req` blocks new column cycles from the next column boundary on and closes the row. Once precharged, `refresh_gnt` is raised with both strobes high, and `req_ready` stays low until `refresh_req` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted this cycle when valid is high |
| req_addr | input | 2*AW | Row (upper half) and column (lower half) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write word including check bits |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | DW | Read word |
| refresh_req | input | 1 | Ask for the array to be closed for refresh |
| refresh_gnt | output | 1 | Array is closed and precharged for refresh |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | AW | Multiplexed row/column address |
| dram_dq_out | output | DW | Data driven toward the array |
| dram_dq_oe | output | 1 | Enable for the data driver |
| dram_dq_in | input | DW | Data returned by the array |

## Verification
Refresh and a page hit can compete in the same cycle: while the row is open, a same-row request and `refresh_req` are raised on the same clock. The bench expects the hit to be refused (`req_ready` low), the row strobe to rise, and `refresh_gnt` to follow with both strobes high while `req_ready` stays low. After the refresh request is withdrawn, the waiting hit must be served through a new row activation, and its data is read back later. The page-length guard is a second path that competes with hits. A long burst of same-row reads must be cut into several row openings, and every read word must still match.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
package fpm_pkg;

  typedef enum logic [2:0] {
    ST_PRE,   // row strobe high, precharge running
    ST_IDLE,  // precharged, waiting for work
    ST_ACT,   // row strobe low, row address on the bus
    ST_CAS,   // column strobe low, access window
    ST_CP,    // column strobe high, column precharge
    ST_OPEN   // row open, waiting for a hit or a reason to close
  } fpm_state_t;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpm_timer.sv
`timescale 1ns/1ps
module fpm_timer #(
  parameter int TW      = 4,
  parameter int RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          done
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= TW'(RST_VAL);
    else if (load)        cnt <= val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // a load always sets up a window of at least one cycle; done only after it ends
  p_load_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (load && val != '0) |=> !done);
endmodule

// File: rtl/fpm_page_guard.sv
`timescale 1ns/1ps
module fpm_page_guard #(
  parameter int LIMIT = 100,
  parameter int CW    = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic row_open,
  output logic expire
);
  logic [CW-1:0] open_cnt;

  always_ff @(posedge clk) begin
    if (rst || !row_open)            open_cnt <= '0;
    else if (open_cnt != {CW{1'b1}}) open_cnt <= open_cnt + 1'b1;
  end

  assign expire = (open_cnt >= CW'(LIMIT));
endmodule

// File: rtl/fpm_ctrl.sv
`timescale 1ns/1ps
module fpm_ctrl #(
  parameter int CLK_NS     = 5,
  parameter bit FAST_GRADE = 1'b1,
  parameter int AW         = 12,
  parameter int DW         = 72,
  parameter int RAS_MAX_NS = 200000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2*AW-1:0] req_addr,
  input  logic            req_write,
  input  logic [DW-1:0]   req_wdata,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  input  logic            refresh_req,
  output logic            refresh_gnt,
  output logic            dram_ras_n,
  output logic            dram_cas_n,
  output logic            dram_we_n,
  output logic            dram_oe_n,
  output logic [AW-1:0]   dram_addr,
  output logic [DW-1:0]   dram_dq_out,
  output logic            dram_dq_oe,
  input  logic [DW-1:0]   dram_dq_in
);
  import fpm_pkg::*;

  // analog minimums per grade, in ns
  localparam int NS_RP  = FAST_GRADE ? 30 : 40;
  localparam int NS_RAC = FAST_GRADE ? 50 : 60;
  localparam int NS_CAC = FAST_GRADE ? 18 : 20;
  localparam int NS_PC  = FAST_GRADE ? 35 : 40;
  localparam int NS_RC  = FAST_GRADE ? 90 : 110;
  localparam int NS_RCD = 18;
  localparam int NS_CP  = 10;

  // cycle counts; the extra OPEN cycle between columns counts toward the page cycle
  localparam int T_RCD  = ns2cyc(NS_RCD, CLK_NS);
  localparam int T_CP   = ns2cyc(NS_CP, CLK_NS);
  localparam int T_CASL = imax(imax(ns2cyc(NS_CAC, CLK_NS), ns2cyc(NS_RAC, CLK_NS) - T_RCD),
                               ns2cyc(NS_PC, CLK_NS) - T_CP - 1);
  localparam int T_RP   = imax(ns2cyc(NS_RP, CLK_NS),
                               ns2cyc(NS_RC, CLK_NS) - (T_RCD + T_CASL + T_CP + 2));
  localparam int RAS_MAX_CYC = RAS_MAX_NS / CLK_NS;
  localparam int GUARD       = T_CASL + T_CP + 4;
  localparam int PAGE_LIMIT  = RAS_MAX_CYC - GUARD;
  localparam int CW          = $clog2(RAS_MAX_CYC + 1);
  localparam int TW          = $clog2(imax(imax(T_RP, T_RCD), imax(T_CASL, T_CP)) + 1);

  localparam logic [TW-1:0] LD_RP   = TW'(T_RP - 1);
  localparam logic [TW-1:0] LD_RCD  = TW'(T_RCD - 1);
  localparam logic [TW-1:0] LD_CASL = TW'(T_CASL - 1);
  localparam logic [TW-1:0] LD_CP   = TW'(T_CP - 1);

  fpm_state_t st, st_n;
  logic [AW-1:0] row_q, col_q;
  logic          wr_q;
  logic [DW-1:0] wd_q;
  logic          tmr_done, tmr_load;
  logic [TW-1:0] tmr_val;
  logic          page_exp;
  logic          accept, hit, eff_wr, capture;
  logic [AW-1:0] req_row, req_col, eff_row, eff_col;
  logic [DW-1:0] eff_wd;

  assign req_row = req_addr[2*AW-1:AW];
  assign req_col = req_addr[AW-1:0];
  assign hit     = (req_row == row_q);

  always_comb begin
    req_ready = 1'b0;
    if (st == ST_IDLE) req_ready = !refresh_req;
    if (st == ST_OPEN) req_ready = !refresh_req && !page_exp && hit;
  end
  assign accept  = req_valid && req_ready;
  assign eff_row = accept ? req_row   : row_q;
  assign eff_col = accept ? req_col   : col_q;
  assign eff_wr  = accept ? req_write : wr_q;
  assign eff_wd  = accept ? req_wdata : wd_q;
  assign capture = (st == ST_CAS) && tmr_done && !wr_q;

  always_comb begin
    st_n     = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st)
      ST_PRE:  if (tmr_done) st_n = ST_IDLE;
      ST_IDLE: if (accept) begin st_n = ST_ACT; tmr_load = 1'b1; tmr_val = LD_RCD; end
      ST_ACT:  if (tmr_done) begin st_n = ST_CAS; tmr_load = 1'b1; tmr_val = LD_CASL; end
      ST_CAS:  if (tmr_done) begin st_n = ST_CP; tmr_load = 1'b1; tmr_val = LD_CP; end
      ST_CP:   if (tmr_done) st_n = ST_OPEN;
      ST_OPEN: begin
        if (accept) begin
          st_n = ST_CAS; tmr_load = 1'b1; tmr_val = LD_CASL;
        end else if (refresh_req || page_exp || req_valid) begin
          st_n = ST_PRE; tmr_load = 1'b1; tmr_val = LD_RP;
        end
      end
      default: st_n = ST_PRE;
    endcase
  end

  fpm_timer #(.TW(TW), .RST_VAL(T_RP - 1)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .done(tmr_done)
  );

  fpm_page_guard #(.LIMIT(PAGE_LIMIT), .CW(CW)) u_guard (
    .clk(clk), .rst(rst), .row_open(!dram_ras_n), .expire(page_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_PRE;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_dq_oe  <= 1'b0;
      dram_addr   <= '0;
      dram_dq_out <= '0;
      row_q       <= '0;
      col_q       <= '0;
      wr_q        <= 1'b0;
      wd_q        <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      refresh_gnt <= 1'b0;
    end else begin
      st <= st_n;
      if (accept) begin
        row_q <= req_row;
        col_q <= req_col;
        wr_q  <= req_write;
        wd_q  <= req_wdata;
      end
      dram_ras_n <= (st_n == ST_PRE) || (st_n == ST_IDLE);
      dram_cas_n <= (st_n != ST_CAS);
      dram_we_n  <= !((st_n == ST_CAS) && eff_wr);
      dram_oe_n  <= !((st_n == ST_CAS) && !eff_wr);
      dram_dq_oe <= (st_n == ST_CAS) && eff_wr;
      if (st_n == ST_CAS) dram_dq_out <= eff_wd;
      if (st_n == ST_ACT)      dram_addr <= eff_row;
      else if (st_n == ST_CAS) dram_addr <= eff_col;
      rd_valid <= capture;
      if (capture) rd_data <= dram_dq_in;
      refresh_gnt <= (st == ST_IDLE) && refresh_req;
    end
  end

  // ---------------- checker state and assertions ----------------
  logic [7:0]    chk_hi;
  logic [CW-1:0] chk_lo;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_hi <= '0;
      chk_lo <= '0;
    end else begin
      chk_hi <= dram_ras_n ? ((chk_hi == 8'hFF) ? chk_hi : chk_hi + 1'b1) : '0;
      chk_lo <= dram_ras_n ? '0 : ((chk_lo == {CW{1'b1}}) ? chk_lo : chk_lo + 1'b1);
    end
  end

  p_prech_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> (32'(chk_hi) >= T_RP));
  p_rcd_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_cas_n) |-> (32'(chk_lo) >= T_RCD));
  p_cas_in_row_r2: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n |-> !dram_ras_n);
  p_early_write_r8: assert property (@(posedge clk) disable iff (rst)
    !dram_we_n |-> (dram_oe_n && dram_dq_oe && !dram_cas_n));
  p_oe_read_r7: assert property (@(posedge clk) disable iff (rst)
    !dram_oe_n |-> (dram_we_n && !dram_cas_n && !dram_dq_oe));
  p_rd_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  p_ras_max_r9: assert property (@(posedge clk) disable iff (rst)
    !dram_ras_n |-> (32'(chk_lo) < RAS_MAX_CYC));
  p_gnt_closed_r10: assert property (@(posedge clk) disable iff (rst)
    refresh_gnt |-> (dram_ras_n && dram_cas_n));
endmodule

// File: tb/sim_fpm_ctrl.sv
`timescale 1ns/1ps
module sim_fpm_ctrl;
  localparam int AW = 12, DW = 72, CLK_NS = 5, RASMAX_NS = 400;
  // expected cycle counts, fast grade, from the requirement text
  localparam int E_RP     = (30 + CLK_NS - 1) / CLK_NS;
  localparam int E_RCD    = (18 + CLK_NS - 1) / CLK_NS;
  localparam int E_CP     = (10 + CLK_NS - 1) / CLK_NS;
  localparam int E_PC     = (35 + CLK_NS - 1) / CLK_NS;
  localparam int E_RASMAX = RASMAX_NS / CLK_NS;

  typedef struct packed {
    logic [2*AW-1:0] a;
    logic            w;
    logic [DW-1:0]   d;
  } op_t;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic req_valid = 1'b0, req_write = 1'b0, refresh_req = 1'b0;
  logic [2*AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, dq_in = '0;
  logic req_ready, rd_valid, refresh_gnt, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [DW-1:0] rd_data, dq_out;
  logic [AW-1:0] maddr;

  fpm_ctrl #(.CLK_NS(CLK_NS), .FAST_GRADE(1'b1), .AW(AW), .DW(DW), .RAS_MAX_NS(RASMAX_NS)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .refresh_req(refresh_req), .refresh_gnt(refresh_gnt), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
    .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(maddr), .dram_dq_out(dq_out),
    .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference state
  op_t             op_q[$];
  logic [DW-1:0]   rd_q[$];
  logic [DW-1:0]   exp_mem[logic [2*AW-1:0]];
  logic [DW-1:0]   dmem[logic [2*AW-1:0]];
  int ras_falls = 0;

  // memory-side model and protocol monitor, compared every clock
  int hi_run = 0, lo_run = 0, chi_run = 0, clo_run = 0, since_cf = 0;
  bit prev_ras = 1'b1, prev_cas = 1'b1, first_cas = 1'b1, cur_wr = 1'b0;
  logic [AW-1:0] lat_row = '0;
  logic [2*AW-1:0] cur_key = '0;
  logic [DW-1:0] cur_wd = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_ras && !ras_n) begin
        chk(hi_run >= E_RP, "R3 precharge", DW'(hi_run), DW'(E_RP));
        lat_row = maddr; ras_falls++; first_cas = 1'b1;
      end
      if (!prev_ras && ras_n)
        chk(lo_run <= E_RASMAX, "R9 row-low length", DW'(lo_run), DW'(E_RASMAX));
      if (prev_cas && !cas_n) begin
        op_t op;
        chk(lo_run >= E_RCD, "R4 row-to-column", DW'(lo_run), DW'(E_RCD));
        if (!first_cas) begin
          chk(since_cf >= E_PC, "R5 page cycle", DW'(since_cf), DW'(E_PC));
          chk(chi_run >= E_CP, "R5 column high", DW'(chi_run), DW'(E_CP));
        end
        first_cas = 1'b0; since_cf = 0;
        cur_key = {lat_row, maddr};
        if (op_q.size() == 0) begin
          chk(1'b0, "R2 unexpected column cycle", DW'(cur_key), '0);
          cur_wr = 1'b0;
        end else begin
          op = op_q.pop_front();
          chk(cur_key == op.a, "R2 address mux", DW'(cur_key), DW'(op.a));
          cur_wr = op.w;
          if (op.w) begin
            chk(!we_n && oe_n && dq_oe && dq_out == op.d, "R8 early write", dq_out, op.d);
            dmem[cur_key] = dq_out; cur_wd = op.d;
          end else
            chk(we_n && !oe_n && !dq_oe, "R7 read strobes", DW'({we_n, oe_n, dq_oe}), DW'(3'b100));
        end
      end
      if (!cas_n && cur_wr && clo_run == 2)
        chk(dq_oe && dq_out == cur_wd, "R8 write data hold", dq_out, cur_wd);
      if (!oe_n && (cas_n || !we_n))
        chk(1'b0, "R7 output enable outside read", DW'({cas_n, we_n}), DW'(2'b01));
      // array data: valid only once both access times have elapsed at the next edge
      if (!cas_n && !oe_n && dmem.exists(cur_key)) begin
        if ((clo_run + 1) * CLK_NS >= 18 && (lo_run + 1) * CLK_NS >= 50) dq_in <= dmem[cur_key];
        else dq_in <= ~dmem[cur_key];
      end else dq_in <= '0;
      if (rd_valid) begin
        if (rd_q.size() == 0) chk(1'b0, "R7 unexpected read", rd_data, '0);
        else begin
          logic [DW-1:0] e;
          e = rd_q.pop_front();
          chk(rd_data == e, "R7 read data", rd_data, e);
        end
      end
      if (ras_n) begin hi_run++; lo_run = 0; end else begin lo_run++; hi_run = 0; end
      if (cas_n) begin chi_run++; clo_run = 0; end else begin clo_run++; chi_run = 0; end
      since_cf++;
      prev_ras = ras_n; prev_cas = cas_n;
    end
  end

  task automatic note_accept(input logic [2*AW-1:0] a, input logic w, input logic [DW-1:0] d);
    op_t o;
    o.a = a; o.w = w; o.d = d;
    op_q.push_back(o);
    if (w) exp_mem[a] = d;
    else rd_q.push_back(exp_mem[a]);
  endtask

  task automatic do_op(input logic [AW-1:0] r, input logic [AW-1:0] c, input logic w, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = {r, c}; req_write = w; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    note_accept({r, c}, w, d);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  function automatic logic [DW-1:0] pat(input int k);
    return {8'(k * 37 + 5), 32'(k * 32'h9E3779B1), 32'(~(k * 32'h7F4A7C15))};
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int n, rf;
    repeat (4) @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n && !dq_oe && !req_ready, "R1 reset state",
        DW'({ras_n, cas_n, we_n, oe_n, dq_oe, req_ready}), DW'(6'b111100));
    rst = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!req_ready && n < 50);
    chk(n == E_RP, "R1 ready after precharge", DW'(n), DW'(E_RP));
    chk(ras_n && cas_n && we_n && oe_n, "R1 idle strobes", DW'({ras_n, cas_n, we_n, oe_n}), DW'(4'hF));

    // R5: page writes then page reads on one row
    rf = ras_falls;
    for (int c = 1; c <= 4; c++) do_op(12'h005, 12'(c), 1'b1, pat(c));
    repeat (3) @(negedge clk);
    for (int c = 1; c <= 4; c++) do_op(12'h005, 12'(c), 1'b0, '0);
    repeat (20) @(negedge clk);
    chk(ras_falls - rf == 1, "R5 single row opening for hits", DW'(ras_falls - rf), DW'(1));

    // R6: row change forces precharge and reopen
    rf = ras_falls;
    do_op(12'h9A3, 12'h007, 1'b1, pat(40));
    do_op(12'h005, 12'h002, 1'b0, '0);
    do_op(12'h9A3, 12'h007, 1'b0, '0);
    repeat (20) @(negedge clk);
    chk(ras_falls - rf == 3, "R6 row miss reopens", DW'(ras_falls - rf), DW'(3));

    // R10: refresh and a page hit presented in the same cycle
    do_op(12'h005, 12'h003, 1'b0, '0);
    repeat (15) @(negedge clk);
    rf = ras_falls;
    @(negedge clk);
    req_valid = 1'b1; req_addr = {12'h005, 12'h009}; req_write = 1'b1; req_wdata = pat(77);
    refresh_req = 1'b1;
    #1;
    chk(!req_ready, "R10 hit refused under refresh", DW'(req_ready), '0);
    n = 0;
    while (!refresh_gnt && n < 60) begin @(negedge clk); n++; end
    chk(refresh_gnt && ras_n && cas_n && !req_ready, "R10 grant with row closed",
        DW'({refresh_gnt, ras_n, cas_n, req_ready}), DW'(4'b1110));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(!req_ready && ras_n, "R10 held off while requested", DW'({req_ready, ras_n}), DW'(2'b01));
    end
    refresh_req = 1'b0;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    note_accept({12'h005, 12'h009}, 1'b1, pat(77));
    @(posedge clk); #1;
    req_valid = 1'b0;
    do_op(12'h005, 12'h009, 1'b0, '0);
    repeat (20) @(negedge clk);
    chk(ras_falls - rf == 1, "R10 new row opening after refresh", DW'(ras_falls - rf), DW'(1));
    chk(!refresh_gnt, "R10 grant released", DW'(refresh_gnt), '0);

    // R9: long same-row burst must be split by the page guard
    rf = ras_falls;
    for (int k = 0; k < 24; k++) do_op(12'h005, 12'((k % 4) + 1), 1'b0, '0);
    repeat (30) @(negedge clk);
    chk(ras_falls - rf >= 2, "R9 page closed during burst", DW'(ras_falls - rf), DW'(2));

    // mixed read-after-write on the same row (R8 then R7)
    do_op(12'h005, 12'h00C, 1'b1, pat(91));
    do_op(12'h005, 12'h00C, 1'b0, '0);
    repeat (30) @(negedge clk);
    chk(rd_q.size() == 0 && op_q.size() == 0, "R7 all requests completed",
        DW'(rd_q.size() + op_q.size()), '0);
    finish_run();
  end
endmodule